// File: doc/BRIEF.md
# Cluster Global Configuration Registers

This block is the register file that a multi-core cluster uses for its shared settings. A single 64-bit register bus reaches it. Each access carries an address, a read or write strobe, write data and the index of the core that issued it. The global area holds a configuration word, the block's own base address and a revision number. It also holds two relocatable window registers: one places the interrupt controller and the other places the power controller. Each window register drives a base output and an enable output, and the outer address decoder uses these to steer accesses into the window.

Every core owns a small bank with two registers. One is a reset-vector base, which drives that core's exception-base output. The other is a selector that names a second core. Software can reach a bank in two ways. The core-local window always lands on the requesting core's own bank. The core-other window lands on the bank that the requester's selector names. This lets one core set the boot vector of another core without knowing a per-core address.

Top module: `cluster_cfg_regs`

## Requirements
- R1: After reset both window registers are zero, so both window bases and both enables are 0. Every selector is 0, and every core's exception base is 64'hFFFF_FFFF_BFC0_0000.
- R2: An access to the core-local block (address 0x2000 + offset) reaches the bank of the core given on `bus_core`.
- R3: An access to the core-other block (address 0x4000 + offset) reaches the bank whose index is held in the requesting core's selector.
- R4: A write to a selector (offset 0x18) through either block is accepted only when `wdata[7:0]` is less than NCORE. Otherwise the selector keeps its value.
- R5: The per-core configuration word (offset 0x10) reads NCORE-1 in both per-core blocks. The global configuration word (address 0x000) reads 0.
- R6: Address 0x030 reads the REV_VAL parameter and address 0x008 reads the SELF_BASE parameter. Address 0x130 reads 64'h0010_0000, which is the cache-bypass flag in bit 20.
- R7: A write to a window register (interrupt controller at 0x080, power controller at 0x088) stores `wdata & 64'h0000_FFFF_FFFF_0001`. The window base output carries bits 47:16 of the stored value, and the enable output carries bit 0. A read returns the stored value.
- R8: The status words read 1 when the sub-device is present and 0 when it is absent: 0x0D0 for the interrupt controller and 0x0F0 for the power controller. A write to the window register of an absent sub-device is ignored.
- R9: A write to a reset-base register (offset 0x20) stores `wdata[31:0] & 32'hFFFF_F000`. A read returns the stored value zero-extended. The core's exception-base output shows the stored value sign-extended from bit 31 in the cycle after the write.
- R10: Reads of unmapped addresses return 0. Writes to unmapped or read-only addresses change no register. A request whose `bus_core` is NCORE or greater is treated as unmapped in the per-core blocks.
- R11: `bus_rvalid` is high in exactly the cycle after a cycle with `bus_rd` high, and `bus_rdata` carries the addressed value in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Byte address of the access |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 64 | Write data |
| bus_core | input | CW | Index of the requesting core |
| bus_rdata | output | 64 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid |
| exc_base | output | 64*NCORE | Exception base per core, core i in bits i*64 +: 64 |
| irq_win_base | output | 64 | Interrupt-controller window base |
| irq_win_en | output | 1 | Interrupt-controller window enable |
| pwr_win_base | output | 64 | Power-controller window base |
| pwr_win_en | output | 1 | Power-controller window enable |

## Verification
The hardest case to reach is a chained redirection. One core first points its selector at another core. It then writes through the core-other block, either to the target's reset base or to the target's own selector. The result can only be seen by reading back as the target core, or on the target's exception-base output. The bench runs with four cores and builds this chain step by step. It also issues a selector write of exactly NCORE and a write whose discarded upper bits are set, so that the range check is tested at its edge. The power controller is configured absent, so that the dropped-write path is exercised.

// File: rtl/cluster_cfg_regs.sv
module cluster_cfg_regs #(
  parameter int          NCORE       = 1,
  parameter logic [63:0] REV_VAL     = 64'h800,
  parameter logic [63:0] SELF_BASE   = 64'h0000_0000_1FBF_8000,
  parameter bit          IRQ_PRESENT = 1'b1,
  parameter bit          PWR_PRESENT = 1'b1,
  localparam int         CW          = (NCORE > 1) ? $clog2(NCORE) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [15:0]         bus_addr,
  input  logic                bus_rd,
  input  logic                bus_wr,
  input  logic [63:0]         bus_wdata,
  input  logic [CW-1:0]       bus_core,
  output logic [63:0]         bus_rdata,
  output logic                bus_rvalid,
  output logic [64*NCORE-1:0] exc_base,
  output logic [63:0]         irq_win_base,
  output logic                irq_win_en,
  output logic [63:0]         pwr_win_base,
  output logic                pwr_win_en
);
  localparam logic [63:0] WIN_MASK  = 64'h0000_FFFF_FFFF_0001;
  localparam logic [31:0] RB_MASK   = 32'hFFFF_F000;
  localparam logic [31:0] RB_RESET  = 32'hBFC0_0000 & RB_MASK;
  localparam logic [63:0] L2_BYPASS = 64'h0010_0000;
  localparam logic [63:0] CORE_CFG  = 64'(NCORE - 1);

  localparam logic [12:0] G_CFG  = 13'h000, G_SELF = 13'h008, G_REV  = 13'h030;
  localparam logic [12:0] G_IRQ  = 13'h080, G_PWR  = 13'h088;
  localparam logic [12:0] G_IRQS = 13'h0D0, G_PWRS = 13'h0F0, G_L2   = 13'h130;
  localparam logic [12:0] C_CFG  = 13'h010, C_SEL  = 13'h018, C_RB   = 13'h020;

  logic [NCORE-1:0][CW-1:0] sel_q;
  logic [NCORE-1:0][31:0]   rb_q;
  logic [63:0]              irq_q, pwr_q;
  logic [63:0]              rd_mux;

  wire [12:0]   off     = bus_addr[12:0];
  wire          in_glb  = bus_addr[15:13] == 3'd0;
  wire          in_loc  = bus_addr[15:13] == 3'd1;
  wire          in_oth  = bus_addr[15:13] == 3'd2;
  wire          core_ok = 32'(bus_core) < NCORE;
  wire [CW-1:0] me      = core_ok ? bus_core : '0;
  wire [CW-1:0] tgt     = in_oth ? sel_q[me] : me;
  wire          bank    = (in_loc || in_oth) && core_ok;
  wire          sel_ok  = 32'(bus_wdata[7:0]) < NCORE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= '0;
      pwr_q <= '0;
      for (int i = 0; i < NCORE; i++) begin
        sel_q[i] <= '0;
        rb_q[i]  <= RB_RESET;
      end
    end else if (bus_wr) begin
      if (in_glb && off == G_IRQ && IRQ_PRESENT) irq_q <= bus_wdata & WIN_MASK;
      if (in_glb && off == G_PWR && PWR_PRESENT) pwr_q <= bus_wdata & WIN_MASK;
      if (bank && off == C_RB) rb_q[tgt] <= bus_wdata[31:0] & RB_MASK;
      if (bank && off == C_SEL && sel_ok) sel_q[tgt] <= bus_wdata[CW-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (in_glb) begin
      case (off)
        G_CFG:   rd_mux = '0;
        G_SELF:  rd_mux = SELF_BASE;
        G_REV:   rd_mux = REV_VAL;
        G_IRQ:   rd_mux = irq_q;
        G_PWR:   rd_mux = pwr_q;
        G_IRQS:  rd_mux = 64'(IRQ_PRESENT);
        G_PWRS:  rd_mux = 64'(PWR_PRESENT);
        G_L2:    rd_mux = L2_BYPASS;
        default: rd_mux = '0;
      endcase
    end else if (bank) begin
      case (off)
        C_CFG:   rd_mux = CORE_CFG;
        C_SEL:   rd_mux = 64'(sel_q[tgt]);
        C_RB:    rd_mux = 64'(rb_q[tgt]);
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end

  for (genvar i = 0; i < NCORE; i++) begin : g_exc
    assign exc_base[i*64 +: 64] = {{32{rb_q[i][31]}}, rb_q[i]};
  end

  assign irq_win_base = {irq_q[63:1], 1'b0};
  assign irq_win_en   = irq_q[0];
  assign pwr_win_base = {pwr_q[63:1], 1'b0};
  assign pwr_win_en   = pwr_q[0];
endmodule

// File: rtl/cluster_cfg_regs_chk.sv
module cluster_cfg_regs_chk #(
  parameter int  NCORE = 1,
  localparam int CW    = (NCORE > 1) ? $clog2(NCORE) : 1
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     bus_rd,
  input logic                     bus_wr,
  input logic [15:0]              bus_addr,
  input logic                     bus_rvalid,
  input logic [63:0]              bus_rdata,
  input logic [64*NCORE-1:0]      exc_base,
  input logic [63:0]              irq_win_base,
  input logic                     irq_win_en,
  input logic [63:0]              pwr_win_base,
  input logic                     pwr_win_en,
  input logic [NCORE-1:0][CW-1:0] sel_q
);
  AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid); // R11
  AST_NO_STRAY_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_rvalid); // R11
  AST_GLOBAL_CFG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 16'h0000) |=> bus_rdata == 64'd0); // R5
  AST_WIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> ($stable(irq_win_base) && $stable(irq_win_en) && $stable(pwr_win_base) && $stable(pwr_win_en))); // R7
  AST_EXC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(exc_base)); // R9
  for (genvar i = 0; i < NCORE; i++) begin : g_sel
    AST_SEL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      32'(sel_q[i]) < NCORE); // R4
  end
endmodule

bind cluster_cfg_regs cluster_cfg_regs_chk #(.NCORE(NCORE)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .exc_base(exc_base),
  .irq_win_base(irq_win_base), .irq_win_en(irq_win_en),
  .pwr_win_base(pwr_win_base), .pwr_win_en(pwr_win_en), .sel_q(sel_q)
);

// File: tb/cluster_cfg_regs_bench.sv
`timescale 1ns/1ps
module cluster_cfg_regs_bench;
  localparam int N = 4;
  localparam logic [63:0] SELF = 64'h0000_0000_1FBF_8000;
  localparam logic [63:0] RST_EXC = 64'hFFFF_FFFF_BFC0_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic bus_rd = 1'b0, bus_wr = 1'b0;
  logic [63:0] bus_wdata = '0;
  logic [1:0] bus_core = '0;
  logic [63:0] bus_rdata, irq_win_base, pwr_win_base;
  logic bus_rvalid, irq_win_en, pwr_win_en;
  logic [64*N-1:0] exc_base;

  int checks = 0, failures = 0;
  logic [63:0] exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  cluster_cfg_regs #(.NCORE(N), .REV_VAL(64'h800), .SELF_BASE(SELF),
                     .IRQ_PRESENT(1'b1), .PWR_PRESENT(1'b0)) u_cluster_cfg_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_core(bus_core), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .exc_base(exc_base), .irq_win_base(irq_win_base),
    .irq_win_en(irq_win_en), .pwr_win_base(pwr_win_base), .pwr_win_en(pwr_win_en));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] core, input logic [15:0] a, input logic [63:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus_core = core; bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [1:0] core, input logic [15:0] a, input logic [63:0] d);
    bus_core = core; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R11 rvalid without a pending read actual=1 expected=0");
      end else begin
        chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < N; i++) chk("R1 exc reset", exc_base[i*64 +: 64], RST_EXC);
    chk("R1 irq base reset", irq_win_base, 64'd0);
    chk("R1 irq en reset", 64'(irq_win_en), 64'd0);
    chk("R1 pwr en reset", 64'(pwr_win_en), 64'd0);
    rd(2'd2, 16'h2018, 64'd0, "R1 selector reset");

    rd(2'd0, 16'h0000, 64'd0, "R5 global cfg");
    rd(2'd1, 16'h2010, 64'd3, "R5 local cfg");
    rd(2'd2, 16'h4010, 64'd3, "R5 other cfg");
    rd(2'd0, 16'h0030, 64'h800, "R6 revision");
    rd(2'd0, 16'h0008, SELF, "R6 self base");
    rd(2'd0, 16'h0130, 64'h0010_0000, "R6 l2 bypass");

    wr(2'd1, 16'h2020, 64'hFFFF_0000_1234_5678);
    chk("R9 exc core1", exc_base[64 +: 64], 64'h0000_0000_1234_5000);
    chk("R2 exc core0 untouched", exc_base[0 +: 64], RST_EXC);
    wr(2'd2, 16'h2020, 64'h0000_0000_8000_1FFF);
    chk("R9 exc core2 sign", exc_base[128 +: 64], 64'hFFFF_FFFF_8000_1000);
    rd(2'd1, 16'h2020, 64'h0000_0000_1234_5000, "R2 local rb core1");
    rd(2'd2, 16'h2020, 64'h0000_0000_8000_1000, "R2 local rb core2");

    wr(2'd0, 16'h2018, 64'd3);
    rd(2'd0, 16'h2018, 64'd3, "R4 selector accepted");
    wr(2'd0, 16'h4020, 64'h0000_0000_0ABC_D123);
    chk("R3 exc core3 via other", exc_base[192 +: 64], 64'h0000_0000_0ABC_D000);
    chk("R3 exc core0 untouched", exc_base[0 +: 64], RST_EXC);
    rd(2'd0, 16'h4020, 64'h0000_0000_0ABC_D000, "R3 other rb read");
    rd(2'd3, 16'h2020, 64'h0000_0000_0ABC_D000, "R3 target local read");

    wr(2'd0, 16'h2018, 64'd4);
    rd(2'd0, 16'h2018, 64'd3, "R4 selector equal NCORE dropped");
    wr(2'd0, 16'h2018, 64'h0000_0000_0000_0104);
    rd(2'd0, 16'h2018, 64'd3, "R4 masked value 4 dropped");
    wr(2'd0, 16'h4018, 64'd1);
    rd(2'd3, 16'h2018, 64'd1, "R3 selector written via other");
    rd(2'd0, 16'h2018, 64'd3, "R3 requester selector kept");
    rd(2'd3, 16'h4020, 64'h0000_0000_1234_5000, "R3 chained other read");

    wr(2'd0, 16'h0080, 64'h0000_ABCD_1234_5679);
    chk("R7 irq base", irq_win_base, 64'h0000_ABCD_1234_0000);
    chk("R7 irq en", 64'(irq_win_en), 64'd1);
    rd(2'd0, 16'h0080, 64'h0000_ABCD_1234_0001, "R7 irq readback");
    wr(2'd0, 16'h0080, 64'hFFFF_FFFF_FFFF_FFFE);
    chk("R7 irq base masked", irq_win_base, 64'h0000_FFFF_FFFF_0000);
    chk("R7 irq disabled", 64'(irq_win_en), 64'd0);

    rd(2'd0, 16'h00D0, 64'd1, "R8 irq status");
    rd(2'd0, 16'h00F0, 64'd0, "R8 pwr status");
    wr(2'd0, 16'h0088, 64'h0000_1111_2222_0001);
    chk("R8 pwr base ignored", pwr_win_base, 64'd0);
    chk("R8 pwr en ignored", 64'(pwr_win_en), 64'd0);
    rd(2'd0, 16'h0088, 64'd0, "R8 pwr readback");

    rd(2'd0, 16'h0040, 64'd0, "R10 unmapped global");
    rd(2'd1, 16'h2028, 64'd0, "R10 unmapped local");
    rd(2'd1, 16'h6020, 64'd0, "R10 unmapped block");
    wr(2'd0, 16'h0030, 64'h1234);
    rd(2'd0, 16'h0030, 64'h800, "R10 revision read-only");
    wr(2'd1, 16'h2010, 64'h55);
    rd(2'd1, 16'h2010, 64'd3, "R10 core cfg read-only");
    wr(2'd1, 16'h6020, 64'h0000_0000_7000_0000);
    chk("R10 unmapped write core1", exc_base[64 +: 64], 64'h0000_0000_1234_5000);

    repeat (2) @(negedge clk);
    chk("R11 all reads answered", 64'(exp_q.size()), 64'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule